// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the effective address and the updated pointer value for a data-write access, and it can step the pointer in bit-reversed order so that radix-2 FFT results are stored in scrambled sequence without extra arithmetic in software. Each request supplies the current pointer, the pointer-register index, the addressing mode, the access size, a read/write qualifier and a modifier word. The modifier word has an enable in its top bit and a pivot in its lower bits. The pivot is half the buffer length, counted in words.

When every activation condition holds, the pointer is advanced by adding the doubled pivot with a carry that runs from the most significant address bit down toward bit 1. The normal increment step is not used, and address bit 0 is cleared. In every other case the block falls back to ordinary linear indirect addressing. A flag reports that the bit-reversed path was taken, so that a companion circular-buffer unit on the write path can stand down. Results are registered and appear one cycle after the request.

Top module: `brev_agu`

## Requirements
- R1: While reset is asserted, and after it until the first request, `out_valid_o`, `brev_o`, `ea_o` and `wb_o` are all zero.
- R2: The bit-reversed path is taken only if all of the following hold: `sel_i` is not 15, `mod_i[15]` is 1, `word_i` is 1, `wr_i` is 1, and `mode_i` is post-increment (1) or pre-increment (3). When it is taken, `brev_o` is 1 together with the result.
- R3: On the bit-reversed path, `wb_o` equals the pointer plus `{mod_i[14:0],1'b0}`, where the sum covers bits 15..1 and carries propagate from higher to lower bits. Any carry out of bit 1 is dropped. This is the same as reversing bits 15..1 of both operands, adding them, and reversing the result back.
- R4: On the bit-reversed path the word or byte step is not added. In post-increment mode `ea_o` is the pointer with bit 0 cleared. In pre-increment mode `ea_o` equals `wb_o`.
- R5: On the bit-reversed path, bit 0 of both `ea_o` and `wb_o` is 0, even when bit 0 of the pointer is 1.
- R6: In every other case the addressing is linear. The step is 2 for a word access (`word_i`=1) and 1 for a byte access. Mode 1 is post-increment and mode 2 is post-decrement: `ea_o` is the pointer and `wb_o` is the pointer plus or minus the step. Mode 3 is pre-increment and mode 4 is pre-decrement: `ea_o` and `wb_o` both equal the pointer plus or minus the step. Mode 0 and modes 5 to 7 are plain indirect: both outputs equal the pointer.
- R7: With a 16-word buffer based at an address whose low 5 bits are zero, a pivot of 8 and post-increment mode, the successive word offsets are 0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 15, and the sequence then wraps back to 0.
- R8: Each request produces `out_valid_o` one cycle later. In a cycle with no request, `out_valid_o` falls and `ea_o` and `wb_o` keep their previous values.
- R9: `brev_o` is 1 only while `out_valid_o` is 1, so it never remains set through idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe for this cycle |
| ptr_i | input | 16 | Current pointer register value (byte address) |
| mod_i | input | 16 | Modifier word: bit 15 is the enable, bits 14:0 are the pivot in words |
| sel_i | input | 4 | Index of the pointer register in use; 15 is the stack pointer |
| mode_i | input | 3 | Addressing mode: 0 indirect, 1 post-inc, 2 post-dec, 3 pre-inc, 4 pre-dec |
| word_i | input | 1 | 1 for a word access, 0 for a byte access |
| wr_i | input | 1 | 1 for a data write, 0 for a read |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| ea_o | output | 16 | Effective address of the access |
| wb_o | output | 16 | Updated pointer value to write back |
| brev_o | output | 1 | Bit-reversed path taken; the companion circular-buffer logic must disable itself |

## Verification
The assertions assume that the inputs are stable and free of X whenever `req_valid_i` is high, and that `req_valid_i` is low while reset is asserted. They also assume that any pointer used with bit-reversed stepping lies in a buffer whose low address bits are zero, sized to the pivot. The stimulus holds `req_valid_i` low throughout reset and drives every input on the falling clock edge. It builds the 16-step sequence from a base of 0x0200, which has its low bits cleared, and it sends the odd-pointer, byte, read, stack-register and disabled-enable cases as separate requests. Each such request changes exactly one activation condition, so every expected result follows from a single rule.

// File: rtl/brev_agu_pkg.sv
package brev_agu_pkg;

  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_POSTDEC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_PREDEC  = 3'd4
  } am_mode_e;

  // Decode a raw mode code; unlisted codes behave as plain indirect
  function automatic am_mode_e am_decode(input logic [2:0] code);
    am_mode_e m;
    case (code)
      3'd1:    m = AM_POSTINC;
      3'd2:    m = AM_POSTDEC;
      3'd3:    m = AM_PREINC;
      3'd4:    m = AM_PREDEC;
      default: m = AM_IND;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/brev_qualify.sv
module brev_qualify
  import brev_agu_pkg::*;
#(
  parameter int SW        = 4,
  parameter int STACK_SEL = 15
) (
  input  logic [SW-1:0] sel_i,
  input  logic          en_i,
  input  am_mode_e      mode_i,
  input  logic          word_i,
  input  logic          wr_i,
  output logic          take_o
);

  logic sel_ok;
  logic mode_ok;

  always_comb begin
    sel_ok  = (sel_i != SW'(STACK_SEL));
    mode_ok = (mode_i == AM_POSTINC) || (mode_i == AM_PREINC);
    take_o  = sel_ok && en_i && mode_ok && word_i && wr_i;
  end

endmodule

// File: rtl/brev_rc_adder.sv
// Reverse-carry adder: carries move from the most significant bit downward
module brev_rc_adder #(
  parameter int N = 15
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o
);

  logic [N-1:0] cy;

  assign cy[N-1] = 1'b0;

  for (genvar k = N - 1; k >= 0; k--) begin : g_bit
    assign sum_o[k] = a_i[k] ^ b_i[k] ^ cy[k];
    if (k > 0) begin : g_cy
      assign cy[k-1] = (a_i[k] & b_i[k]) | (cy[k] & (a_i[k] ^ b_i[k]));
    end
  end

endmodule

// File: rtl/lin_addr_step.sv
module lin_addr_step
  import brev_agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  am_mode_e      mode_i,
  input  logic          word_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_o
);

  logic [AW-1:0] step;
  logic [AW-1:0] up;
  logic [AW-1:0] dn;

  always_comb begin
    step = word_i ? AW'(2) : AW'(1);
    up   = ptr_i + step;
    dn   = ptr_i - step;
    case (mode_i)
      AM_POSTINC: begin ea_o = ptr_i; wb_o = up;    end
      AM_POSTDEC: begin ea_o = ptr_i; wb_o = dn;    end
      AM_PREINC:  begin ea_o = up;    wb_o = up;    end
      AM_PREDEC:  begin ea_o = dn;    wb_o = dn;    end
      default:    begin ea_o = ptr_i; wb_o = ptr_i; end
    endcase
  end

endmodule

// File: rtl/brev_agu.sv
module brev_agu
  import brev_agu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int SW        = 4,
  parameter int STACK_SEL = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] mod_i,
  input  logic [SW-1:0] sel_i,
  input  logic [2:0]    mode_i,
  input  logic          word_i,
  input  logic          wr_i,
  output logic          out_valid_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_o,
  output logic          brev_o
);

  localparam int EN_BIT = AW - 1;
  localparam int RW     = AW - 1;

  am_mode_e      mode;
  logic          take;
  logic [AW-1:0] lin_ea;
  logic [AW-1:0] lin_wb;
  logic [RW-1:0] rev_sum;
  logic [AW-1:0] rev_wb;
  logic [AW-1:0] rev_ea;

  logic [AW-1:0] ea_d,  ea_q;
  logic [AW-1:0] wb_d,  wb_q;
  logic          br_d,  br_q;
  logic          vld_q;

  assign mode = am_decode(mode_i);

  brev_qualify #(.SW(SW), .STACK_SEL(STACK_SEL)) u_qual (
    .sel_i  (sel_i),
    .en_i   (mod_i[EN_BIT]),
    .mode_i (mode),
    .word_i (word_i),
    .wr_i   (wr_i),
    .take_o (take)
  );

  lin_addr_step #(.AW(AW)) u_lin (
    .ptr_i  (ptr_i),
    .mode_i (mode),
    .word_i (word_i),
    .ea_o   (lin_ea),
    .wb_o   (lin_wb)
  );

  // Pivot is counted in words; its doubled form lines up with bits AW-1..1
  brev_rc_adder #(.N(RW)) u_rca (
    .a_i   (ptr_i[AW-1:1]),
    .b_i   (mod_i[RW-1:0]),
    .sum_o (rev_sum)
  );

  always_comb begin
    rev_wb = {rev_sum, 1'b0};
    rev_ea = (mode == AM_PREINC) ? rev_wb : {ptr_i[AW-1:1], 1'b0};
    if (take) begin
      ea_d = rev_ea;
      wb_d = rev_wb;
      br_d = 1'b1;
    end else begin
      ea_d = lin_ea;
      wb_d = lin_wb;
      br_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q <= '0;
      wb_q <= '0;
      br_q <= 1'b0;
    end else if (req_valid_i) begin
      ea_q <= ea_d;
      wb_q <= wb_d;
      br_q <= br_d;
    end
  end

  assign out_valid_o = vld_q;
  assign ea_o        = ea_q;
  assign wb_o        = wb_q;
  assign brev_o      = br_q & vld_q;

endmodule

// File: rtl/brev_agu_chk.sv
module brev_agu_chk #(
  parameter int AW        = 16,
  parameter int SW        = 4,
  parameter int STACK_SEL = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] ptr_i,
  input logic [AW-1:0] mod_i,
  input logic [SW-1:0] sel_i,
  input logic [2:0]    mode_i,
  input logic          word_i,
  input logic          wr_i,
  input logic          out_valid_o,
  input logic [AW-1:0] ea_o,
  input logic [AW-1:0] wb_o,
  input logic          brev_o
);

  logic cond_full;
  assign cond_full = (sel_i != SW'(STACK_SEL)) && mod_i[AW-1] && word_i && wr_i
                     && (mode_i == 3'd1 || mode_i == 3'd3);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> out_valid_o); // R8
  AST_IDLE_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !out_valid_o); // R8
  AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(ea_o) && $stable(wb_o))); // R8
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brev_o |-> (ea_o[0] == 1'b0 && wb_o[0] == 1'b0)); // R5
  AST_GATED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cond_full) |=> !brev_o); // R2
  AST_GATED_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cond_full) |=> brev_o); // R2
  AST_POST_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cond_full && mode_i == 3'd1) |=>
      (ea_o == {$past(ptr_i[AW-1:1]), 1'b0})); // R4
  AST_PRE_EA_IS_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cond_full && mode_i == 3'd3) |=> (ea_o == wb_o)); // R4
  AST_FLAG_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brev_o |-> out_valid_o); // R9

endmodule

bind brev_agu brev_agu_chk #(.AW(AW), .SW(SW), .STACK_SEL(STACK_SEL)) u_chk (.*);

// File: tb/brev_agu_tb.sv
module brev_agu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] ptr;
  logic [AW-1:0] modw;
  logic [3:0]    sel;
  logic [2:0]    mode;
  logic          word;
  logic          wr;
  logic          out_valid;
  logic [AW-1:0] ea;
  logic [AW-1:0] wb;
  logic          brev;

  int n_vec;
  int n_bad;
  logic [AW-1:0] last_ea;
  logic [AW-1:0] last_wb;

  logic [AW-1:0] q_ea[$];
  logic [AW-1:0] q_wb[$];
  logic          q_br[$];
  string         q_tag[$];

  brev_agu u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .ptr_i       (ptr),
    .mod_i       (modw),
    .sel_i       (sel),
    .mode_i      (mode),
    .word_i      (word),
    .wr_i        (wr),
    .out_valid_o (out_valid),
    .ea_o        (ea),
    .wb_o        (wb),
    .brev_o      (brev)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reverse bits 15..1, add, reverse back
  function automatic logic [AW-1:0] ref_revadd(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-2:0] ra, rb, s;
    logic [AW-1:0] r;
    for (int j = 1; j < AW; j++) begin
      ra[AW-1-j] = a[j];
      rb[AW-1-j] = b[j];
    end
    s = ra + rb;
    r = '0;
    for (int j = 1; j < AW; j++) r[j] = s[AW-1-j];
    return r;
  endfunction

  function automatic logic [3:0] rev4(input logic [3:0] x);
    return {x[0], x[1], x[2], x[3]};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] p, input logic [AW-1:0] m, input logic [3:0] s,
                      input logic [2:0] md, input logic w, input logic wrt, input string tag);
    logic take;
    logic [AW-1:0] step, e_ea, e_wb;
    take = (s != 4'd15) && m[15] && w && wrt && (md == 3'd1 || md == 3'd3);
    step = w ? 16'd2 : 16'd1;
    if (take) begin
      e_wb = ref_revadd(p, {m[14:0], 1'b0});
      e_ea = (md == 3'd3) ? e_wb : {p[AW-1:1], 1'b0};
    end else begin
      case (md)
        3'd1:    begin e_ea = p;        e_wb = p + step; end
        3'd2:    begin e_ea = p;        e_wb = p - step; end
        3'd3:    begin e_ea = p + step; e_wb = p + step; end
        3'd4:    begin e_ea = p - step; e_wb = p - step; end
        default: begin e_ea = p;        e_wb = p;        end
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1;
    ptr = p; modw = m; sel = s; mode = md; word = w; wr = wrt;
    q_ea.push_back(e_ea);
    q_wb.push_back(e_wb);
    q_br.push_back(take);
    q_tag.push_back(tag);
    last_ea = e_ea;
    last_wb = e_wb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pop and compare on every valid result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_ea.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R8: got unexpected result, expected none pending");
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " ea"}, ea, q_ea.pop_front());
        check({t, " wb"}, wb, q_wb.pop_front());
        check({t, " flag R2"}, {15'd0, brev}, {15'd0, q_br.pop_front()});
      end
    end
  end

  initial begin
    n_vec = 0; n_bad = 0;
    req_valid = 1'b0; ptr = '0; modw = '0; sel = '0; mode = '0; word = 1'b0; wr = 1'b0;
    last_ea = '0; last_wb = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", {15'd0, out_valid}, 16'd0);
    check("R1 ea", ea, 16'd0);
    check("R1 wb", wb, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag", {15'd0, brev}, 16'd0);

    // R7: 16-word bit-reversed sequence from base 0x0200, pivot 8
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] p;
      p = 16'h0200 + {11'd0, rev4(4'(k)), 1'b0};
      send(p, 16'h8008, 4'd3, 3'd1, 1'b1, 1'b1, "R7 seq");
    end
    idle(2);
    check("R7 wrap", last_wb, 16'h0200);

    // R3/R4: pre-increment and mixed pivots
    send(16'h1234, 16'h8003, 4'd2, 3'd3, 1'b1, 1'b1, "R3 pre");
    send(16'h0A0E, 16'h8100, 4'd7, 3'd1, 1'b1, 1'b1, "R3 post");
    send(16'hFFFE, 16'hFFFF, 4'd0, 3'd3, 1'b1, 1'b1, "R3 allones");
    // R5: odd pointer on the reversed path
    send(16'h0211, 16'h8008, 4'd1, 3'd1, 1'b1, 1'b1, "R5 odd post");
    send(16'h0211, 16'h8008, 4'd1, 3'd3, 1'b1, 1'b1, "R5 odd pre");
    // R6/R2: each condition broken on its own
    send(16'h0210, 16'h8008, 4'd15, 3'd1, 1'b1, 1'b1, "R6 stack");
    send(16'h0210, 16'h0008, 4'd1,  3'd1, 1'b1, 1'b1, "R6 disabled");
    send(16'h0210, 16'h8008, 4'd1,  3'd1, 1'b0, 1'b1, "R6 byte");
    send(16'h0210, 16'h8008, 4'd1,  3'd1, 1'b1, 1'b0, "R6 read");
    send(16'h0210, 16'h8008, 4'd1,  3'd2, 1'b1, 1'b1, "R6 postdec");
    send(16'h0210, 16'h8008, 4'd1,  3'd4, 1'b0, 1'b1, "R6 predec byte");
    send(16'h0210, 16'h8008, 4'd1,  3'd0, 1'b1, 1'b1, "R6 ind");
    send(16'h0210, 16'h8008, 4'd1,  3'd6, 1'b1, 1'b1, "R6 code6");
    send(16'h0000, 16'h0000, 4'd4,  3'd4, 1'b1, 1'b1, "R6 wrap down");
    send(16'h0400, 16'h8001, 4'd5,  3'd3, 1'b1, 1'b1, "R2 active pre");
    idle(3);

    // R8/R9: idle hold
    check("R8 idle valid", {15'd0, out_valid}, 16'd0);
    check("R8 hold ea", ea, last_ea);
    check("R8 hold wb", wb, last_wb);
    check("R9 flag idle", {15'd0, brev}, 16'd0);
    check("R8 drained", 16'(q_ea.size()), 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule